// File: doc/BRIEF.md
# Fault Recording Ring

This block logs fault events into a small ring of 128-bit recording slots. A fault arrives as a one-cycle strobe with a 127-bit payload. The block keeps a write index that points at the slot for the next fault. If that slot is free, the payload goes into the slot, the slot's valid flag is set, and the index moves one step around the ring. If that slot still holds an unserviced fault, the new fault is dropped and an overflow flag is raised. The block does not skip ahead and does not overwrite. Recording therefore stops at the first occupied slot, and only the cleared slots before it can accept new faults.

Software reads slots through a 32-bit word-addressed register port. It services faults oldest first and frees each slot by writing one to that slot's valid flag. A status register reports four things: whether any fault is pending, the overflow flag, a record index for software, and the hardware write index. The record index moves only when software frees the slot it points at, so it can lag behind the write index. An interrupt line pulses on each recorded fault. It also pulses on the drop that first sets overflow, unless a mask bit blocks it.

Top module: `fault_log_ring`

## Requirements
- R1: A fault strobe is recorded when the slot at the write index has its valid flag clear. The payload is stored, the valid flag is set, and the write index becomes (index+1) modulo NUM_SLOTS.
- R2: A fault strobe is dropped when the slot at the write index has its valid flag set. The slot contents and the write index stay unchanged, and the overflow flag is set.
- R3: Slot word addresses are slot*4+w for w = 0..3. Word w returns payload bits [32w+31:32w]. Word 3 returns the valid flag in bit 31 and payload bits [126:96] in bits 30:0. Read data appears the cycle after reg_rd and shows the state before that edge. Addresses above the control register read 0, and writes to them have no effect.
- R4: A write to word address slot*4+3 with bit 31 set clears that slot's valid flag. Every other write to a slot word address leaves the slot unchanged.
- R5: The status register sits at word address NUM_SLOTS*4. Bit 0 is set when any slot is valid. Bit 1 is the overflow flag. Bits 15:8 hold the record index and bits 23:16 hold the write index. All other bits read 0.
- R6: The record index advances by one, modulo NUM_SLOTS, only when software clears the valid flag of the slot it points at and that flag was set. Otherwise it holds.
- R7: Writing status with bit 1 set clears the overflow flag. The next dropped fault then raises the interrupt again.
- R8: irq_o is high for exactly the cycle after a recorded fault. It is also high for the cycle after a dropped fault, but only if overflow was clear in that cycle (after any same-cycle clear). A drop while overflow is already set gives no pulse.
- R9: The control register sits at word address NUM_SLOTS*4+1. Its bit 0 is a readable mask. While the mask is 1, irq_o stays low.
- R10: If a valid-flag clear and a fault strobe hit the same slot in one cycle, the clear is applied first and the fault is recorded in that slot.
- R11: After reset, all valid flags, the overflow flag, both indices, the mask and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault strobe, one per cycle |
| flt_payload | input | 127 | Fault payload |
| reg_addr | input | ADDR_W | Register word address, shared by read and write |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read enable |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with NUM_SLOTS=4, so the address is 5 bits wide and the status and control registers sit at word addresses 16 and 17. With only four slots, a few faults fill the ring. This makes the wrap of the write index, the stall at an occupied slot, the repeat drops while overflow is set, and the lag between record index and write index occur in nearly every stretch of the random run. The random mix also overlaps clears with strobes on the same slot often, and it toggles the mask while faults are being dropped.

// File: rtl/frr_pkg.sv
package frr_pkg;
  localparam int WORD_W         = 32;
  localparam int WORDS_PER_SLOT = 4;
  localparam int SLOT_W         = WORD_W * WORDS_PER_SLOT;
  localparam int PAYLOAD_W      = SLOT_W - 1;
  localparam int VALID_BIT      = WORD_W - 1;
  localparam int FLAG_WORD      = WORDS_PER_SLOT - 1;

  localparam int STAT_PEND_BIT  = 0;
  localparam int STAT_OVF_BIT   = 1;
  localparam int STAT_RIDX_LSB  = 8;
  localparam int STAT_WIDX_LSB  = 16;
  localparam int IDX_FIELD_W    = 8;

  typedef enum logic [1:0] {
    SEL_SLOT = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/frr_slot_store.sv
module frr_slot_store
  import frr_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rec_en,
  input  logic [IDX_W-1:0]     rec_idx,
  input  logic [PAYLOAD_W-1:0] rec_data,
  input  logic [NUM_SLOTS-1:0] clr_vec,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_slot,
  input  logic [1:0]           rd_word,
  output logic [NUM_SLOTS-1:0] vld_q,
  output logic [WORD_W-1:0]    rd_data
);
  logic [NUM_SLOTS-1:0] rec_mask;
  logic [WORD_W-1:0]    word_q [WORDS_PER_SLOT];
  logic [1:0]           rd_wsel_q;
  logic                 rd_vld_q;

  assign rec_mask = rec_en ? (NUM_SLOTS'(1) << rec_idx) : '0;

  // valid flags: clear first, then record
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= (vld_q & ~clr_vec) | rec_mask;
  end

  // one memory per payload word, each with a registered read port
  for (genvar w = 0; w < WORDS_PER_SLOT; w++) begin : g_word
    localparam int WW = (w == FLAG_WORD) ? WORD_W - 1 : WORD_W;
    logic [WW-1:0] mem [NUM_SLOTS];
    logic [WW-1:0] q;
    always_ff @(posedge clk) begin
      if (rec_en) mem[rec_idx] <= rec_data[w*WORD_W +: WW];
      if (rd_en)  q <= mem[rd_slot];
    end
    assign word_q[w] = WORD_W'(q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_wsel_q <= '0;
      rd_vld_q  <= 1'b0;
    end else if (rd_en) begin
      rd_wsel_q <= rd_word;
      rd_vld_q  <= vld_q[rd_slot];
    end
  end

  always_comb begin
    rd_data = word_q[rd_wsel_q];
    if (rd_wsel_q == 2'(FLAG_WORD)) rd_data[VALID_BIT] = rd_vld_q;
  end

  p_rec_sets_valid_r1: assert property (@(posedge clk) disable iff (rst)
    rec_en |=> vld_q[$past(rec_idx)]);

  p_clear_drops_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_vec != '0 && !rec_en) |=> ((vld_q & $past(clr_vec)) == '0));
endmodule

// File: rtl/frr_write_ctrl.sv
module frr_write_ctrl #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flt_valid,
  input  logic [NUM_SLOTS-1:0] vld_q,
  input  logic [NUM_SLOTS-1:0] clr_vec,
  input  logic                 ovf_clr,
  output logic                 rec_en,
  output logic [IDX_W-1:0]     widx_q,
  output logic                 ovf_q,
  output logic                 irq_evt
);
  logic slot_busy;
  logic drop;
  logic ovf_eff;

  assign slot_busy = vld_q[widx_q] & ~clr_vec[widx_q];
  assign rec_en    = flt_valid & ~slot_busy;
  assign drop      = flt_valid & slot_busy;
  assign ovf_eff   = ovf_q & ~ovf_clr;
  assign irq_evt   = rec_en | (drop & ~ovf_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      widx_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (rec_en)
        widx_q <= (widx_q == IDX_W'(NUM_SLOTS - 1)) ? '0 : widx_q + 1'b1;
      ovf_q <= ovf_eff | drop;
    end
  end

  p_rec_step_r1: assert property (@(posedge clk) disable iff (rst)
    rec_en |=> (widx_q == (($past(widx_q) == IDX_W'(NUM_SLOTS - 1)) ? '0 : $past(widx_q) + 1'b1)));

  p_drop_hold_index_r2: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && vld_q[widx_q] && !clr_vec[widx_q]) |=> $stable(widx_q));

  p_drop_sets_ovf_r2: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf_q);

  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !flt_valid) |=> !ovf_q);
endmodule

// File: rtl/frr_reg_if.sv
module frr_reg_if
  import frr_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = $clog2(NUM_SLOTS),
  parameter int ADDR_W    = $clog2(NUM_SLOTS * 4 + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [WORD_W-1:0]    reg_wdata,
  input  logic                 reg_rd,
  input  logic [NUM_SLOTS-1:0] vld_q,
  input  logic [IDX_W-1:0]     widx_q,
  input  logic                 ovf_q,
  input  logic                 irq_evt,
  input  logic [WORD_W-1:0]    slot_rdata,
  output logic [NUM_SLOTS-1:0] clr_vec,
  output logic                 ovf_clr,
  output logic                 st_rd_en,
  output logic [IDX_W-1:0]     st_rd_slot,
  output logic [1:0]           st_rd_word,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 irq_o
);
  localparam int SLOT_WORDS = NUM_SLOTS * WORDS_PER_SLOT;
  localparam int STAT_ADDR  = SLOT_WORDS;
  localparam int CTRL_ADDR  = SLOT_WORDS + 1;

  logic              in_slots;
  logic              hit_stat;
  logic              hit_ctrl;
  logic [IDX_W-1:0]  addr_slot;
  logic [1:0]        addr_word;
  logic              mask_q;
  logic [IDX_W-1:0]  ridx_q;
  logic              ridx_adv;
  logic [WORD_W-1:0] stat_w;
  logic [WORD_W-1:0] stat_snap_q;
  logic              mask_snap_q;
  rd_sel_e           sel_q;

  assign in_slots  = reg_addr < ADDR_W'(SLOT_WORDS);
  assign hit_stat  = reg_addr == ADDR_W'(STAT_ADDR);
  assign hit_ctrl  = reg_addr == ADDR_W'(CTRL_ADDR);
  assign addr_slot = reg_addr[IDX_W+1:2];
  assign addr_word = reg_addr[1:0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_clr
    assign clr_vec[s] = reg_wr && in_slots && (addr_slot == IDX_W'(s)) &&
                        (addr_word == 2'(FLAG_WORD)) && reg_wdata[VALID_BIT];
  end

  assign ovf_clr  = reg_wr && hit_stat && reg_wdata[STAT_OVF_BIT];
  assign ridx_adv = clr_vec[ridx_q] && vld_q[ridx_q];

  assign st_rd_en   = reg_rd && in_slots;
  assign st_rd_slot = addr_slot;
  assign st_rd_word = addr_word;

  always_comb begin
    stat_w = '0;
    stat_w[STAT_PEND_BIT] = |vld_q;
    stat_w[STAT_OVF_BIT]  = ovf_q;
    stat_w[STAT_RIDX_LSB +: IDX_FIELD_W] = IDX_FIELD_W'(ridx_q);
    stat_w[STAT_WIDX_LSB +: IDX_FIELD_W] = IDX_FIELD_W'(widx_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= 1'b0;
      ridx_q      <= '0;
      irq_o       <= 1'b0;
      sel_q       <= SEL_NONE;
      stat_snap_q <= '0;
      mask_snap_q <= 1'b0;
    end else begin
      if (reg_wr && hit_ctrl) mask_q <= reg_wdata[0];
      if (ridx_adv)
        ridx_q <= (ridx_q == IDX_W'(NUM_SLOTS - 1)) ? '0 : ridx_q + 1'b1;
      irq_o <= irq_evt & ~mask_q;
      if (reg_rd) begin
        stat_snap_q <= stat_w;
        mask_snap_q <= mask_q;
        if (in_slots)      sel_q <= SEL_SLOT;
        else if (hit_stat) sel_q <= SEL_STAT;
        else if (hit_ctrl) sel_q <= SEL_CTRL;
        else               sel_q <= SEL_NONE;
      end
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_SLOT: reg_rdata = slot_rdata;
      SEL_STAT: reg_rdata = stat_snap_q;
      SEL_CTRL: reg_rdata = {{(WORD_W-1){1'b0}}, mask_snap_q};
      default:  reg_rdata = '0;
    endcase
  end

  p_mask_blocks_irq_r9: assert property (@(posedge clk) disable iff (rst)
    mask_q |=> !irq_o);

  p_ridx_step_r6: assert property (@(posedge clk) disable iff (rst)
    ridx_adv |=> (ridx_q != $past(ridx_q)));

  p_ridx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ridx_adv |=> $stable(ridx_q));
endmodule

// File: rtl/fault_log_ring.sv
module fault_log_ring
  import frr_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int ADDR_W   = $clog2(NUM_SLOTS * 4 + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flt_valid,
  input  logic [PAYLOAD_W-1:0] flt_payload,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [WORD_W-1:0]    reg_wdata,
  input  logic                 reg_rd,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 irq_o
);
  logic [NUM_SLOTS-1:0] vld_q;
  logic [NUM_SLOTS-1:0] clr_vec;
  logic                 ovf_clr;
  logic                 rec_en;
  logic [IDX_W-1:0]     widx_q;
  logic                 ovf_q;
  logic                 irq_evt;
  logic                 st_rd_en;
  logic [IDX_W-1:0]     st_rd_slot;
  logic [1:0]           st_rd_word;
  logic [WORD_W-1:0]    slot_rdata;

  frr_slot_store #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rec_en   (rec_en),
    .rec_idx  (widx_q),
    .rec_data (flt_payload),
    .clr_vec  (clr_vec),
    .rd_en    (st_rd_en),
    .rd_slot  (st_rd_slot),
    .rd_word  (st_rd_word),
    .vld_q    (vld_q),
    .rd_data  (slot_rdata)
  );

  frr_write_ctrl #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_wctrl (
    .clk       (clk),
    .rst       (rst),
    .flt_valid (flt_valid),
    .vld_q     (vld_q),
    .clr_vec   (clr_vec),
    .ovf_clr   (ovf_clr),
    .rec_en    (rec_en),
    .widx_q    (widx_q),
    .ovf_q     (ovf_q),
    .irq_evt   (irq_evt)
  );

  frr_reg_if #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .vld_q      (vld_q),
    .widx_q     (widx_q),
    .ovf_q      (ovf_q),
    .irq_evt    (irq_evt),
    .slot_rdata (slot_rdata),
    .clr_vec    (clr_vec),
    .ovf_clr    (ovf_clr),
    .st_rd_en   (st_rd_en),
    .st_rd_slot (st_rd_slot),
    .st_rd_word (st_rd_word),
    .reg_rdata  (reg_rdata),
    .irq_o      (irq_o)
  );
endmodule

// File: tb/fault_log_ring_bench.sv
`timescale 1ns/1ps
module fault_log_ring_bench;
  localparam int NS   = 4;
  localparam int AW   = 5;
  localparam int SW   = NS * 4;
  localparam int STAT = SW;
  localparam int CTRL = SW + 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           flt_valid = 1'b0;
  logic [126:0]   flt_payload = '0;
  logic [AW-1:0]  reg_addr = '0;
  logic           reg_wr = 1'b0;
  logic [31:0]    reg_wdata = '0;
  logic           reg_rd = 1'b0;
  logic [31:0]    reg_rdata;
  logic           irq_o;

  always #2.5 clk = ~clk;

  fault_log_ring #(.NUM_SLOTS(NS)) u_fault_log_ring (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_payload(flt_payload),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // reference model
  bit           mvld  [NS];
  bit           known [NS];
  logic [126:0] mpay  [NS];
  int           widx, ridx;
  bit           movf, mmask;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mread(int a, output logic [31:0] cm, output string tag);
    logic [31:0] v;
    bit any;
    any = 1'b0;
    for (int i = 0; i < NS; i++) any |= mvld[i];
    cm = 32'hFFFF_FFFF;
    tag = "R3";
    if (a < SW) begin
      int s, w;
      s = a / 4; w = a % 4;
      if (w < 3) begin
        v = mpay[s][w*32 +: 32];
        if (!known[s]) cm = 32'h0;
      end else begin
        v = {mvld[s], mpay[s][126:96]};
        if (!known[s]) cm = 32'h8000_0000;
        tag = "R4";
      end
    end else if (a == STAT) begin
      v = {8'h0, 8'(widx), 8'(ridx), 6'h0, movf, any};
      tag = "R5";
    end else if (a == CTRL) begin
      v = {31'h0, mmask};
      tag = "R9";
    end else v = 32'h0;
    return v;
  endfunction

  task automatic step(bit fv, logic [126:0] fd, bit wr, int a, logic [31:0] wd, bit rd);
    logic [31:0] exp_rd, cm;
    string tag;
    bit ev, ovf_eff, exp_irq;
    flt_valid = fv; flt_payload = fd; reg_wr = wr; reg_addr = AW'(a);
    reg_wdata = wd; reg_rd = rd;
    exp_rd = mread(a, cm, tag);
    if (wr && a < SW && (a % 4) == 3 && wd[31]) begin
      int s;
      s = a / 4;
      if (s == ridx && mvld[s]) ridx = (ridx + 1) % NS;
      mvld[s] = 1'b0;
    end
    ovf_eff = movf && !(wr && a == STAT && wd[1]);
    ev = 1'b0;
    if (fv) begin
      if (!mvld[widx]) begin
        mpay[widx] = fd; mvld[widx] = 1'b1; known[widx] = 1'b1;
        widx = (widx + 1) % NS; ev = 1'b1;
      end else begin
        ev = !ovf_eff; ovf_eff = 1'b1;
      end
    end
    movf = ovf_eff;
    exp_irq = ev && !mmask;
    if (wr && a == CTRL) mmask = wd[0];
    @(posedge clk);
    @(negedge clk);
    chk("R8 irq", {31'h0, irq_o}, {31'h0, exp_irq});
    if (rd) chk(tag, reg_rdata & cm, exp_rd & cm);
    flt_valid = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  function automatic logic [126:0] rpay();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic rd_only(int a); step(1'b0, '0, 1'b0, a, 32'h0, 1'b1); endtask
  task automatic fault(logic [126:0] p); step(1'b1, p, 1'b0, 0, 32'h0, 1'b0); endtask
  task automatic wr_only(int a, logic [31:0] d); step(1'b0, '0, 1'b1, a, d, 1'b0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [126:0] p [6];
    void'($urandom(32'd5150));
    for (int i = 0; i < NS; i++) begin mvld[i] = 0; known[i] = 0; mpay[i] = '0; end
    widx = 0; ridx = 0; movf = 0; mmask = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R11 irq after reset", {31'h0, irq_o}, 32'h0);
    rd_only(STAT); chk("R11 status", reg_rdata, 32'h0);
    rd_only(CTRL); chk("R11 mask", reg_rdata, 32'h0);

    for (int i = 0; i < 6; i++) p[i] = rpay();
    for (int i = 0; i < NS; i++) fault(p[i]);
    rd_only(STAT); chk("R1 wrap status", reg_rdata, 32'h0000_0001);
    rd_only(4);    chk("R3 slot1 word0", reg_rdata, p[1][31:0]);
    rd_only(7);    chk("R3 slot1 word3", reg_rdata, {1'b1, p[1][126:96]});
    rd_only(20);   chk("R3 unmapped", reg_rdata, 32'h0);

    fault(p[4]);
    rd_only(STAT); chk("R2 overflow set", reg_rdata, 32'h0000_0003);
    rd_only(0);    chk("R2 slot0 kept", reg_rdata, p[0][31:0]);
    fault(p[5]);   chk("R8 no pulse while overflow", {31'h0, irq_o}, 32'h0);

    wr_only(0, 32'hFFFF_FFFF);
    wr_only(3, 32'h7FFF_FFFF);
    wr_only(20, 32'hFFFF_FFFF);
    rd_only(0);    chk("R4 junk write ignored", reg_rdata, p[0][31:0]);
    rd_only(3);    chk("R4 flag kept", reg_rdata, {1'b1, p[0][126:96]});

    wr_only(11, 32'h8000_0000);
    fault(rpay());
    rd_only(STAT); chk("R6 record index holds", reg_rdata, 32'h0000_0003);
    wr_only(3, 32'h8000_0000);
    rd_only(STAT); chk("R6 record index steps", reg_rdata, 32'h0000_0103);

    wr_only(STAT, 32'h0000_0002);
    rd_only(STAT); chk("R7 overflow cleared", reg_rdata, 32'h0000_0101);
    fault(rpay());
    rd_only(STAT); chk("R1 record into freed slot", reg_rdata, 32'h0001_0101);
    fault(rpay()); chk("R7 drop after clear pulses", {31'h0, irq_o}, 32'h1);

    p[0] = rpay();
    step(1'b1, p[0], 1'b1, 7, 32'h8000_0000, 1'b0);
    chk("R10 same-slot irq", {31'h0, irq_o}, 32'h1);
    rd_only(4);    chk("R10 payload in slot1", reg_rdata, p[0][31:0]);

    wr_only(CTRL, 32'h1);
    fault(rpay()); chk("R9 masked irq", {31'h0, irq_o}, 32'h0);
    rd_only(CTRL); chk("R9 mask readback", reg_rdata, 32'h1);
    wr_only(CTRL, 32'h0);

    for (int n = 0; n < 4000; n++) begin
      bit fv, wr, rd;
      int a, k;
      logic [31:0] wd;
      fv = ($urandom_range(99) < 45);
      wr = ($urandom_range(99) < 40);
      rd = ($urandom_range(99) < 50);
      a  = $urandom_range(SW + 2);
      wd = $urandom;
      if (wr) begin
        k = $urandom_range(99);
        if (k < 55) begin a = $urandom_range(NS - 1) * 4 + 3; wd[31] = 1'b1; end
        else if (k < 70) a = STAT;
        else if (k < 80) begin a = CTRL; wd[0] = ($urandom_range(3) == 0); end
      end
      step(fv, rpay(), wr, a, wd, rd);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule